// File: doc/BRIEF.md
# Three-Channel Watchdog Timer

This peripheral holds three independent watchdog channels behind one small register port. Each channel keeps a 16-bit down-counter and a limit. It counts down by one on every cycle in which an external tenth-of-a-second tick enable is high. Software arms a channel by writing its limit, which loads the counter and sets the channel running. It keeps the channel alive by reading the counter register, and that read reloads the counter from the limit. If the counter reaches zero, the channel stops and latches an expired flag.

The three channels differ only in what expiry does. Channel 0 raises a level interrupt that stays up until the channel is re-armed. Channel 1 fires a fixed-length reset pulse aimed at the processor. Channel 2 fires a fixed-length reset pulse aimed at the whole board. A shared mask byte can suppress the action of any channel. A masked channel still counts down and still records expiry.

Halfword registers hold their two bytes in the opposite order to the bus. The swap applies on both write and read, so software reads back the same halfword it wrote.

Top module: `wdt3_periph`

## Requirements
- R1: After reset, every channel's counter and limit hold count value 1, which reads as bus halfword 0x0100. Every status byte, the mask and the shared expired byte read 0x00, and irq_o, cpu_rst_o and sys_rst_o are low.
- R2: A halfword write (bus_half_i=1) to a limit register at channel base + 0x4 loads both the limit and the counter, sets running and clears expired. A byte-size write to a limit register changes nothing.
- R3: A running counter drops by one only on cycles where tick_i is high. When a tick meets a count of 1 or 0, the counter becomes 0, running clears and expired sets. A limit of 0 therefore expires on the first tick.
- R4: A read of the counter register at channel base + 0x0 returns the current count and reloads the counter from the limit. A read of the limit register leaves the counter unchanged.
- R5: The count value is the bus halfword with its two bytes exchanged, so writing 0x0500 arms a count of 5. Counter and limit reads return the count re-swapped into bus order.
- R6: The channel status byte at channel base + 0x8 has bit 0 = running and bit 1 = expired, with the upper bits zero. The byte at 0x34 holds the three expired flags in bits 0 to 2.
- R7: Channel bases are 0x00, 0x10 and 0x20. The mask byte is at 0x30, with bit i belonging to channel i. A 1 in bit i suppresses that channel's expiry action, while its counting and its expired flag are unaffected.
- R8: irq_o is high while channel 0 is expired and unmasked, and it drops when a limit write re-arms channel 0.
- R9: An unmasked expiry of channel 1 drives cpu_rst_o high, and an unmasked expiry of channel 2 drives sys_rst_o high. Each output rises in the cycle the expired flag sets and stays high for exactly PULSE_LEN cycles (default 8).
- R10: A read returns its data with bus_rvalid_o one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Tenth-of-a-second count enable |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_half_i | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr_i | input | 6 | Byte address within the block |
| bus_wdata_i | input | 16 | Write data in bus byte order |
| bus_rvalid_o | output | 1 | Read data valid |
| bus_rdata_o | output | 16 | Read data |
| irq_o | output | 1 | Channel 0 expiry interrupt |
| cpu_rst_o | output | 1 | Channel 1 processor reset pulse |
| sys_rst_o | output | 1 | Channel 2 board reset pulse |

## Verification
A counter that decrements off-tick or misses a reload shows up at the next counter read as a wrong value, and a misplaced expiry moves irq_o or a reset pulse by whole tick periods. A mask that gates the counter rather than the action leaves the expired flag clear, which is visible in the status bytes right after the tick. A missing or doubled byte swap corrupts both the read-back halfword and the number of ticks before expiry. A mis-sized reset pulse is caught by counting its high cycles.

// File: rtl/wdt3_pkg.sv
package wdt3_pkg;
  localparam int NCH     = 3;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 6;
  // register offsets inside a 16-byte block
  localparam logic [3:0] OFF_CNT  = 4'h0;
  localparam logic [3:0] OFF_LIM  = 4'h4;
  localparam logic [3:0] OFF_STS  = 4'h8;
  localparam logic [3:0] OFF_MASK = 4'h0;
  localparam logic [3:0] OFF_XSTS = 4'h4;
  localparam logic [1:0] BLK_SHARED = 2'd3;

  function automatic logic [CNT_W-1:0] swap_bytes(input logic [CNT_W-1:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/wdt_chan.sv
module wdt_chan
  import wdt3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             run_o,
  output logic             exp_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic             run_q, run_d, exp_q, exp_d;
  logic             hit;

  assign hit = tick_i && run_q && !load_i && !reload_i && (cnt_q <= CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    run_d = run_q;
    exp_d = exp_q;
    if (load_i) begin
      lim_d = load_val_i;
      cnt_d = load_val_i;
      run_d = 1'b1;
      exp_d = 1'b0;
    end else if (reload_i) begin
      cnt_d = lim_q;
    end else if (hit) begin
      cnt_d = '0;
      run_d = 1'b0;
      exp_d = 1'b1;
    end else if (tick_i && run_q) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(1);
      lim_q <= CNT_W'(1);
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      run_q <= run_d;
      exp_q <= exp_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign lim_o    = lim_q;
  assign run_o    = run_q;
  assign exp_o    = exp_q;
  assign expire_o = hit;

  // R6
  run_exp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && exp_q));
  // R2
  load_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (run_q && !exp_q && cnt_q == $past(load_val_i)));
  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i && !reload_i) |=> $stable(cnt_q));
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && !load_i) |=> (cnt_q == $past(lim_q)));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic pulse_o
);
  localparam int LW = $clog2(LEN + 1);
  logic [LW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)
      cnt_d = LW'(LEN);
    else if (cnt_q != '0)
      cnt_d = cnt_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != '0);

  // R9
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> pulse_o);
endmodule

// File: rtl/wdt3_periph.sv
module wdt3_periph
  import wdt3_pkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic              bus_half_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              sys_rst_o
);
  logic [1:0]       blk;
  logic [3:0]       off;
  logic             wr_en, rd_en;
  logic [CNT_W-1:0] cnt_w [NCH];
  logic [CNT_W-1:0] lim_w [NCH];
  logic [NCH-1:0]   run_w, exp_w, expire_w;
  logic [NCH-1:0]   mask_q, mask_d;
  logic [CNT_W-1:0] rd_mux, rdata_q;
  logic             rvalid_q;
  logic [NCH-1:0]   pulse_w;

  assign blk   = bus_addr_i[5:4];
  assign off   = bus_addr_i[3:0];
  assign wr_en = bus_valid_i && bus_write_i;
  assign rd_en = bus_valid_i && !bus_write_i;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ld, rl;
    assign ld = wr_en && bus_half_i && (blk == 2'(i)) && (off == OFF_LIM);
    assign rl = rd_en && (blk == 2'(i)) && (off == OFF_CNT);
    wdt_chan u_chan (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .load_i(ld), .load_val_i(swap_bytes(bus_wdata_i)), .reload_i(rl),
      .cnt_o(cnt_w[i]), .lim_o(lim_w[i]), .run_o(run_w[i]),
      .exp_o(exp_w[i]), .expire_o(expire_w[i])
    );
  end

  // reset pulse generators for channels 1 and 2
  assign pulse_w[0] = 1'b0;
  for (genvar i = 1; i < NCH; i++) begin : g_rst
    wdt_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n),
      .start_i(expire_w[i] && !mask_q[i]),
      .pulse_o(pulse_w[i])
    );
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_en && blk == BLK_SHARED && off == OFF_MASK)
      mask_d = bus_wdata_i[NCH-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (blk)
      BLK_SHARED: begin
        if (off == OFF_MASK)      rd_mux = CNT_W'(mask_q);
        else if (off == OFF_XSTS) rd_mux = CNT_W'(exp_w);
      end
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (blk == 2'(i)) begin
            if (off == OFF_CNT)      rd_mux = swap_bytes(cnt_w[i]);
            else if (off == OFF_LIM) rd_mux = swap_bytes(lim_w[i]);
            else if (off == OFF_STS) rd_mux = CNT_W'({exp_w[i], run_w[i]});
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign bus_rvalid_o = rvalid_q;
  assign bus_rdata_o  = rdata_q;
  assign irq_o        = exp_w[0] && !mask_q[0];
  assign cpu_rst_o    = pulse_w[1];
  assign sys_rst_o    = pulse_w[2];

  // R9
  cpu_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_o) |-> exp_w[1]);
  // R9
  sys_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> exp_w[2]);
  // R10
  rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> bus_rvalid_o);
endmodule

// File: tb/wdt3_periph_tb.sv
module wdt3_periph_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i, bus_valid_i, bus_write_i, bus_half_i;
  logic [5:0]  bus_addr_i;
  logic [15:0] bus_wdata_i;
  logic        bus_rvalid_o, irq_o, cpu_rst_o, sys_rst_o;
  logic [15:0] bus_rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  localparam int PL = 8;

  always #2.5 clk = ~clk;

  wdt3_periph #(.PULSE_LEN(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i), .bus_half_i(bus_half_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rvalid_o(bus_rvalid_o), .bus_rdata_o(bus_rdata_o),
    .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && bus_rvalid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10: unexpected read data %h expected none", bus_rdata_o);
      end else begin
        chk(tag_q.pop_front(), bus_rdata_o, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic half, input logic [15:0] d);
    @(negedge clk);
    bus_valid_i = 1; bus_write_i = 1; bus_half_i = half; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_valid_i = 0; bus_write_i = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] expv, input string tag);
    exp_q.push_back(expv); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid_i = 1; bus_write_i = 0; bus_half_i = 1; bus_addr_i = a;
    @(negedge clk);
    bus_valid_i = 0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_i = 1;
      @(negedge clk); tick_i = 0;
    end
  endtask

  task automatic pulse_len(input string tag, input bit which);
    int n = 0;
    while ((which ? sys_rst_o : cpu_rst_o) && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(tag, 16'(n), 16'(PL));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; tick_i = 0; bus_valid_i = 0; bus_write_i = 0; bus_half_i = 0;
    bus_addr_i = '0; bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 16'(irq_o), 0);
    chk("R1 cpu_rst", 16'(cpu_rst_o), 0);
    chk("R1 sys_rst", 16'(sys_rst_o), 0);
    rd(6'h00, 16'h0100, "R1 ch0 counter");
    rd(6'h14, 16'h0100, "R1 ch1 limit");
    rd(6'h28, 16'h0000, "R1 ch2 status");
    rd(6'h30, 16'h0000, "R1 mask");
    rd(6'h34, 16'h0000, "R1 shared expired");

    // R2 / R5 arm channel 0 with count 5
    wr(6'h04, 1, 16'h0500);
    rd(6'h08, 16'h0001, "R2 ch0 running");
    rd(6'h04, 16'h0500, "R5 limit readback");
    tick(2);
    rd(6'h00, 16'h0300, "R3 two ticks");
    rd(6'h00, 16'h0500, "R4 counter read reloads");
    rd(6'h04, 16'h0500, "R4 limit read");
    rd(6'h04, 16'h0500, "R4 limit read again");
    tick(1);
    rd(6'h00, 16'h0400, "R4 limit read no side effect");
    repeat (10) @(negedge clk);
    rd(6'h00, 16'h0500, "R3 no tick no count");
    tick(4);
    chk("R8 irq before expiry", 16'(irq_o), 0);
    tick(1);
    chk("R8 irq on expiry", 16'(irq_o), 1);
    rd(6'h08, 16'h0002, "R6 ch0 expired");
    rd(6'h34, 16'h0001, "R6 shared expired");
    tick(2);
    chk("R8 irq held", 16'(irq_o), 1);
    wr(6'h04, 1, 16'h0500);
    chk("R8 irq cleared by limit write", 16'(irq_o), 0);
    rd(6'h08, 16'h0001, "R2 expired cleared");

    // R2 byte-size limit write ignored
    wr(6'h04, 0, 16'h0200);
    rd(6'h04, 16'h0500, "R2 byte write ignored");

    // R9 channel 1 processor reset
    wr(6'h14, 1, 16'h0200);
    tick(1);
    chk("R9 cpu_rst before expiry", 16'(cpu_rst_o), 0);
    tick(1);
    chk("R9 cpu_rst on expiry", 16'(cpu_rst_o), 1);
    chk("R9 sys_rst untouched", 16'(sys_rst_o), 0);
    pulse_len("R9 cpu_rst length", 0);
    rd(6'h18, 16'h0002, "R6 ch1 expired");

    // R7 masked channel 2
    wr(6'h30, 0, 16'h0004);
    rd(6'h30, 16'h0004, "R7 mask readback");
    wr(6'h24, 1, 16'h0100);
    tick(1);
    chk("R7 masked sys_rst", 16'(sys_rst_o), 0);
    rd(6'h28, 16'h0002, "R7 masked channel still expires");
    rd(6'h34, 16'h0006, "R6 shared expired ch1 ch2");
    wr(6'h30, 0, 16'h0000);
    wr(6'h24, 1, 16'h0100);
    tick(1);
    chk("R9 sys_rst on expiry", 16'(sys_rst_o), 1);
    pulse_len("R9 sys_rst length", 1);

    // R7 masked interrupt
    wr(6'h30, 0, 16'h0001);
    wr(6'h04, 1, 16'h0100);
    tick(1);
    chk("R7 masked irq", 16'(irq_o), 0);
    rd(6'h08, 16'h0002, "R7 ch0 expired while masked");

    // R3 zero limit expires on first tick
    wr(6'h30, 0, 16'h0000);
    wr(6'h14, 1, 16'h0000);
    tick(1);
    rd(6'h18, 16'h0002, "R3 zero limit expiry");
    chk("R3 zero limit cpu_rst", 16'(cpu_rst_o), 1);

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R10: actual %0d reads pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule